// File: doc/BRIEF.md
# Cascadable Serial-Load Latched Driver Chain

This block takes a serial bit stream and turns it into a set of parallel "driver on" controls for low-side load switches. Each device holds an 8-bit shift stage, clocked by its own shift clock, and an 8-bit holding register, clocked by a separate latch clock. Data is shifted in while the loads keep their present state. One latch pulse then moves the whole new pattern to the drivers at once. An active-low clear empties only the shift stage, and an active-low enable forces every driver off without touching the latched pattern.

The shift stage's top bit leaves each device as a serial output. This lets devices be chained so that the total shift length grows by eight per device. The top module instantiates a parameterised number of devices (three by default) wired as one chain. It exposes one flat driver vector, in which bit `8*k+i` is bit `i` of device `k`, and device 0 receives the serial input. The power stage and the analog behaviour are not modelled. A driver bit of 1 means that channel's switch is on, pulling its load low.

Top module: `sipo_drv_chain`

## Requirements
- R1: On each rising edge of `shift_clk` (with `stage_clr_n` high and `rst` low), every device's shift stage moves up one position: the incoming serial bit enters bit 0, and bit 7 leaves as that device's serial output.
- R2: A bit shifted into a device sits in bit 7 of that device after 8 shift edges.
- R3: On a rising edge of `latch_clk`, every device's holding register takes the value of its shift stage. The drivers do not change on shift edges alone.
- R4: While `stage_clr_n` is low, all shift stages are zero at once, without waiting for a clock. The clear wins over a coincident shift edge, so a bit presented then is lost.
- R5: The clear has no effect on the holding registers: the drivers keep their latched pattern while it is low.
- R6: While `out_en_n` is high, all bits of `drv_on` are 0, whatever the latched data.
- R7: While `out_en_n` is low, each `drv_on` bit equals its holding-register bit combinationally, where 1 means that channel's switch is on.
- R8: Device k+1 takes its serial input from device k. With N devices, the bit shifted in first reaches `ser_out` and `drv_on[8N-1]` after 8N shift edges.
- R9: When `shift_clk` and `latch_clk` rise together, the holding registers capture the shift-stage value from before that shift.
- R10: `rst` (synchronous, active high) zeroes the shift stages on a `shift_clk` edge and the holding registers on a `latch_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled by each clock for its own register |
| shift_clk | input | 1 | Shift stage clock, rising edge |
| latch_clk | input | 1 | Holding register clock, rising edge |
| ser_in | input | 1 | Serial data into device 0 |
| stage_clr_n | input | 1 | Asynchronous active-low clear of all shift stages |
| out_en_n | input | 1 | Active-low driver enable; high forces all drivers off |
| drv_on | output | 8*N_DEV | Driver on bits, bit 8*k+i belongs to device k channel i |
| ser_out | output | 1 | Bit 7 of the last device's shift stage |

## Verification
On every relevant clock edge, assertions check the one-step shift in each stage, the bit passed across each link of the chain, the capture of the pre-edge stage value on each latch edge, and the all-zero stage while the clear is low. Checks of the enable gating run on every change. The bench scenarios are needed to show the behaviour over whole sequences: the mapping of the first-shifted bit to the top channel after a full 24-bit load, the clear leaving the latched drivers untouched, a bit lost under a clear that overlaps a shift edge, and coincident shift and latch edges capturing the older pattern. A behavioural model in the bench follows every cycle and compares `drv_on` and `ser_out` against it.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;

    localparam int unsigned STAGE_W = 8;

    typedef logic [STAGE_W-1:0] stage_t;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ZERO  = 2'd2
    } stage_op_e;

    // Next value of a shift stage: new bit enters at the bottom.
    function automatic stage_t stage_advance(input stage_t cur, input logic din);
        return {cur[STAGE_W-2:0], din};
    endfunction

    // Driver gating: enable low passes the latched bits, high forces all off.
    function automatic stage_t drive_gate(input stage_t held, input logic en_n);
        return en_n ? '0 : held;
    endfunction

endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage
    import sipo_drv_pkg::*;
(
    input  logic   shift_clk,
    input  logic   rst,
    input  logic   stage_clr_n,
    input  logic   ser_in,
    output stage_t stage_q,
    output logic   ser_out
);

    stage_op_e op;
    stage_t    stage_d;

    always_comb begin
        op = rst ? ST_ZERO : ST_SHIFT;
    end

    always_comb begin
        case (op)
            ST_ZERO:  stage_d = '0;
            ST_SHIFT: stage_d = stage_advance(stage_q, ser_in);
            default:  stage_d = stage_q;
        endcase
    end

    always_ff @(posedge shift_clk or negedge stage_clr_n) begin
        if (!stage_clr_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign ser_out = stage_q[STAGE_W-1];

    AST_CLR_EMPTIES_STAGE: assert property (@(posedge shift_clk) disable iff (rst)
        !stage_clr_n |-> stage_q == '0);  // R4

    AST_STAGE_STEP: assert property (@(posedge shift_clk) disable iff (rst || !stage_clr_n)
        1'b1 |=> stage_q[STAGE_W-1:1] == $past(stage_q[STAGE_W-2:0]));  // R1

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg
    import sipo_drv_pkg::*;
(
    input  logic   latch_clk,
    input  logic   rst,
    input  stage_t stage_q,
    output stage_t hold_q
);

    always_ff @(posedge latch_clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= stage_q;
        end
    end

    AST_LATCH_TAKES_OLD_STAGE: assert property (@(posedge latch_clk) disable iff (rst)
        1'b1 |=> hold_q == $past(stage_q));  // R9

endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate
    import sipo_drv_pkg::*;
(
    input  stage_t hold_q,
    input  logic   out_en_n,
    output stage_t drv_on
);

    stage_t gated;

    always_comb begin
        gated = drive_gate(hold_q, out_en_n);
    end

    for (genvar ch = 0; ch < STAGE_W; ch++) begin : g_chan
        assign drv_on[ch] = gated[ch];
    end

endmodule

// File: rtl/sipo_drv_device.sv
module sipo_drv_device
    import sipo_drv_pkg::*;
(
    input  logic   shift_clk,
    input  logic   latch_clk,
    input  logic   rst,
    input  logic   stage_clr_n,
    input  logic   out_en_n,
    input  logic   ser_in,
    output stage_t stage_q,
    output stage_t hold_q,
    output stage_t drv_on,
    output logic   ser_out
);

    sipo_shift_stage u_stage (
        .shift_clk   (shift_clk),
        .rst         (rst),
        .stage_clr_n (stage_clr_n),
        .ser_in      (ser_in),
        .stage_q     (stage_q),
        .ser_out     (ser_out)
    );

    sipo_hold_reg u_hold (
        .latch_clk (latch_clk),
        .rst       (rst),
        .stage_q   (stage_q),
        .hold_q    (hold_q)
    );

    sipo_out_gate u_gate (
        .hold_q   (hold_q),
        .out_en_n (out_en_n),
        .drv_on   (drv_on)
    );

endmodule

// File: rtl/sipo_drv_chain.sv
module sipo_drv_chain
    import sipo_drv_pkg::*;
#(
    parameter int unsigned N_DEV = 3
) (
    input  logic                     rst,
    input  logic                     shift_clk,
    input  logic                     latch_clk,
    input  logic                     ser_in,
    input  logic                     stage_clr_n,
    input  logic                     out_en_n,
    output logic [N_DEV*STAGE_W-1:0] drv_on,
    output logic                     ser_out
);

    localparam int unsigned CH_TOTAL = N_DEV * STAGE_W;

    logic   [N_DEV:0]        link;
    stage_t [N_DEV-1:0]      stage_all;
    stage_t [N_DEV-1:0]      hold_all;
    stage_t [N_DEV-1:0]      drv_all;
    logic   [CH_TOTAL-1:0]   hold_flat;

    assign link[0] = ser_in;

    for (genvar k = 0; k < N_DEV; k++) begin : g_dev
        sipo_drv_device u_dev (
            .shift_clk   (shift_clk),
            .latch_clk   (latch_clk),
            .rst         (rst),
            .stage_clr_n (stage_clr_n),
            .out_en_n    (out_en_n),
            .ser_in      (link[k]),
            .stage_q     (stage_all[k]),
            .hold_q      (hold_all[k]),
            .drv_on      (drv_all[k]),
            .ser_out     (link[k+1])
        );
        assign drv_on[k*STAGE_W +: STAGE_W]    = drv_all[k];
        assign hold_flat[k*STAGE_W +: STAGE_W] = hold_all[k];
    end

    assign ser_out = link[N_DEV];

    for (genvar k = 0; k + 1 < N_DEV; k++) begin : g_link_chk
        AST_CHAIN_LINK: assert property (@(posedge shift_clk) disable iff (rst || !stage_clr_n)
            1'b1 |=> stage_all[k+1][0] == $past(stage_all[k][STAGE_W-1]));  // R8
    end

    always_comb begin
        if (out_en_n) begin
            AST_DISABLED_ALL_OFF: assert (drv_on == '0);  // R6
        end else begin
            AST_ENABLED_FOLLOWS_HOLD: assert (drv_on == hold_flat);  // R7
        end
    end

endmodule

// File: tb/sipo_drv_chain_bench.sv
module sipo_drv_chain_bench;

    localparam int NDEV = 3;
    localparam int CH   = NDEV * 8;

    logic clk = 1'b0;
    logic rst, sh_en, la_en, ser_in, clr_n, oe_n;
    logic shift_clk, latch_clk;
    logic [CH-1:0] drv_on;
    logic ser_out;

    int tests = 0;
    int fails = 0;

    logic mq [CH];
    logic mh [CH];

    always #2 clk = ~clk;
    assign shift_clk = clk & sh_en;
    assign latch_clk = clk & la_en;

    sipo_drv_chain #(.N_DEV(NDEV)) u_sipo_drv_chain (
        .rst         (rst),
        .shift_clk   (shift_clk),
        .latch_clk   (latch_clk),
        .ser_in      (ser_in),
        .stage_clr_n (clr_n),
        .out_en_n    (oe_n),
        .drv_on      (drv_on),
        .ser_out     (ser_out)
    );

    task automatic check(input logic ok, input string req, input logic [CH-1:0] act,
                         input logic [CH-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [CH-1:0] model_drv();
        logic [CH-1:0] v;
        for (int i = 0; i < CH; i++) v[i] = oe_n ? 1'b0 : mh[i];
        return v;
    endfunction

    // Reference model: behavioural, updated on each clk edge.
    always @(posedge clk) begin
        logic old [CH];
        for (int i = 0; i < CH; i++) old[i] = mq[i];
        if (la_en) begin
            for (int i = 0; i < CH; i++) mh[i] = rst ? 1'b0 : old[i];
        end
        if (!clr_n || (rst && sh_en)) begin
            for (int i = 0; i < CH; i++) mq[i] = 1'b0;
        end else if (sh_en) begin
            for (int i = CH - 1; i > 0; i--) mq[i] = old[i-1];
            mq[0] = ser_in;
        end
    end

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (!clr_n) for (int i = 0; i < CH; i++) mq[i] = 1'b0;
        check(drv_on === model_drv(), "R7 model drv_on", drv_on, model_drv());
        check(ser_out === mq[CH-1], "R1 model ser_out", {{(CH-1){1'b0}}, ser_out},
              {{(CH-1){1'b0}}, mq[CH-1]});
    end

    task automatic cyc(input logic sh, input logic la, input logic d);
        @(negedge clk);
        #1;
        sh_en  = sh;
        la_en  = la;
        ser_in = d;
    endtask

    task automatic load_word(input logic [CH-1:0] w);
        for (int i = CH - 1; i >= 0; i--) cyc(1'b1, 1'b0, w[i]);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [CH-1:0] w1, w2, held;
        w1 = 24'hC3A51E;
        w2 = 24'h5AF00F;
        for (int i = 0; i < CH; i++) begin
            mq[i] = 1'b0;
            mh[i] = 1'b0;
        end
        rst = 1'b1; sh_en = 1'b0; la_en = 1'b0; ser_in = 1'b0;
        clr_n = 1'b1; oe_n = 1'b0;
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        check(drv_on === '0, "R10 reset drivers", drv_on, '0);
        check(ser_out === 1'b0, "R10 reset ser_out", {23'd0, ser_out}, '0);

        // Full load, then latch
        load_word(w1);
        cyc(1'b0, 1'b0, 1'b0);
        check(drv_on === '0, "R3 no change before latch", drv_on, '0);
        check(ser_out === w1[CH-1], "R8 first bit at chain end", {23'd0, ser_out},
              {23'd0, w1[CH-1]});
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        check(drv_on[7:0] === w1[7:0], "R3 device0 byte", drv_on, w1);
        check(drv_on[15:8] === w1[15:8], "R8 device1 byte", drv_on, w1);
        check(drv_on[23:16] === w1[23:16], "R2 device2 byte", drv_on, w1);

        // Enable gating
        oe_n = 1'b1; #0.5;
        check(drv_on === '0, "R6 disabled all off", drv_on, '0);
        oe_n = 1'b0; #0.5;
        check(drv_on === w1, "R7 enabled follows latch", drv_on, w1);

        // Clear: stage empties, drivers keep pattern
        clr_n = 1'b0; #0.5;
        check(ser_out === 1'b0, "R4 clear empties stage", {23'd0, ser_out}, '0);
        check(drv_on === w1, "R5 clear keeps drivers", drv_on, w1);
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        check(drv_on === w1, "R5 drivers after clear", drv_on, w1);
        clr_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        check(drv_on === '0, "R4 clear beat shift edges", drv_on, '0);

        // One device worth of bits
        load_word({16'd0, 8'h6D});
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        check(drv_on === {16'd0, 8'h6D}, "R2 eight shifts fill device0", drv_on,
              {16'd0, 8'h6D});
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        check(drv_on === {15'd0, 8'h6D, 1'b1}, "R1 single step", drv_on,
              {15'd0, 8'h6D, 1'b1});

        // Coincident shift and latch edges
        load_word(w2);
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        check(drv_on === w2, "R9 latch takes pre-shift value", drv_on, w2);
        held = {w2[CH-2:0], 1'b1};
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        check(drv_on === held, "R9 shifted value on next latch", drv_on, held);

        // Mid-run reset
        rst = 1'b1;
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        check(drv_on === '0, "R10 mid-run reset", drv_on, '0);
        cyc(1'b0, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule